// File: doc/BRIEF.md
# Overlapping Register Window File

This block is a register file of 64 physical entries that software reaches only through a 16-entry logical view. The view, called a window, is placed by a 3-bit circular window pointer. A procedure call steps the pointer forward by one window position, which is 8 physical entries. A return steps it back by one position. Because a window is twice as wide as the step, the upper half of the caller's view and the lower half of the callee's view are the same physical registers. Arguments and results therefore pass between caller and callee without any copying.

Two combinational read ports and one synchronous write port each take a 4-bit logical register number. The number is translated to a physical index as (8 × pointer + logical) mod 64.

The block also counts how many windows are resident. A call that would push the count past the limit raises an overflow trap, and a return that finds no resident caller raises an underflow trap. In both cases the window does not move. A trap handler spills or fills one window's worth of registers elsewhere and then pulses the matching acknowledge input. After that the trapped call or return is issued again.

Top module: `regwin_file`

## Requirements
- R1: During and straight after reset the window pointer is 0, the resident count is 1 and both trap outputs are low.
- R2: A read or write at logical register L while the pointer is W reaches physical entry (8·W + L) mod 64, and the write takes effect at the rising clock edge.
- R3: After a call, logical registers 0 to 7 return the values that logical registers 8 to 15 held in the caller's window.
- R4: When a read and a write address the same register in one cycle, the read port shows the old value in that cycle and the new value from the next cycle on.
- R5: A lone call with no trap pending and a resident count below 7 advances the pointer by one (modulo 8) and raises the count by one at the next edge.
- R6: A lone call with no trap pending and a resident count of 7 sets the overflow trap at the next edge and leaves the pointer and the count unchanged.
- R7: A lone return with no trap pending and a resident count above 1 moves the pointer back by one (modulo 8) and lowers the count by one.
- R8: A lone return with no trap pending and a resident count of 1 sets the underflow trap and leaves the pointer and the count unchanged.
- R9: Call and return asserted in the same cycle are both ignored, so the pointer, the count and the traps keep their values.
- R10: A spill acknowledge while the overflow trap is set clears the trap and lowers the count by one, after which the retried call proceeds.
- R11: A fill acknowledge while the underflow trap is set clears the trap and raises the count by one, after which the retried return proceeds.
- R12: While either trap is set, call and return have no effect on the pointer, the count or the traps.
- R13: The pointer wraps circularly, so moving back from position 0 gives position 7, and in window 7 logical registers 8 to 15 reach physical entries 0 to 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of pointer, count and traps |
| rd_a_idx_i | input | 4 | Logical register number for read port A |
| rd_a_data_o | output | 32 | Read port A data (combinational) |
| rd_b_idx_i | input | 4 | Logical register number for read port B |
| rd_b_data_o | output | 32 | Read port B data (combinational) |
| wr_en_i | input | 1 | Write enable |
| wr_idx_i | input | 4 | Logical register number for the write |
| wr_data_i | input | 32 | Write data |
| call_i | input | 1 | Procedure call strobe |
| ret_i | input | 1 | Procedure return strobe |
| spill_ack_i | input | 1 | Handler has spilled one window |
| fill_ack_i | input | 1 | Handler has restored one window |
| cwp_o | output | 3 | Current window pointer |
| resident_o | output | 4 | Number of resident windows |
| ovf_trap_o | output | 1 | Window overflow trap pending |
| unf_trap_o | output | 1 | Window underflow trap pending |

## Verification
The properties assume that an acknowledge is only pulsed for the trap that is pending, and that an acknowledge never shares a cycle with a call or return strobe. Otherwise the pointer-step properties would have to model the acknowledge priority as well.

The stimulus follows these rules. It drives each acknowledge alone, and it exercises a simultaneous call and return only with no acknowledge present. It uses writes alongside strobes only where the translation through the pre-edge pointer is what is being measured. Register contents are compared only for entries the bench itself has written, because the storage has no reset.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

   typedef enum logic [1:0] {
      WOP_NONE = 2'd0,
      WOP_CALL = 2'd1,
      WOP_RET  = 2'd2
   } win_op_e;

   // Simultaneous call and return collapse to no operation.
   function automatic win_op_e decode_op(input logic call, input logic ret);
      if (call && !ret)      return WOP_CALL;
      else if (ret && !call) return WOP_RET;
      else                   return WOP_NONE;
   endfunction

endpackage

// File: rtl/regwin_map.sv
module regwin_map #(
   parameter int NUM_PHYS = 64,
   parameter int WIN_STEP = 8,
   parameter int PTR_W    = 3,
   parameter int LREG_W   = 4,
   parameter int PREG_W   = 6
) (
   input  logic [PTR_W-1:0]  ptr_i,
   input  logic [LREG_W-1:0] lidx_i,
   output logic [PREG_W-1:0] pidx_o
);
   localparam int SUM_W = PREG_W + 1;
   localparam bit POW2  = (NUM_PHYS == (1 << PREG_W));

   logic [SUM_W-1:0] sum;

   always_comb begin
      sum = SUM_W'(ptr_i) * SUM_W'(WIN_STEP) + SUM_W'(lidx_i);
   end

   generate
      if (POW2) begin : g_trunc
         assign pidx_o = sum[PREG_W-1:0];
      end else begin : g_wrap
         always_comb begin
            if (sum >= SUM_W'(NUM_PHYS)) pidx_o = PREG_W'(sum - SUM_W'(NUM_PHYS));
            else                         pidx_o = sum[PREG_W-1:0];
         end
      end
   endgenerate

endmodule

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
   import regwin_pkg::*;
#(
   parameter int NUM_WIN      = 8,
   parameter int MAX_RESIDENT = 7,
   parameter int PTR_W        = 3,
   parameter int CNT_W        = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             call_i,
   input  logic             ret_i,
   input  logic             spill_ack_i,
   input  logic             fill_ack_i,
   output logic [PTR_W-1:0] cwp_o,
   output logic [CNT_W-1:0] resident_o,
   output logic             ovf_o,
   output logic             unf_o
);
   localparam bit PTR_POW2 = (NUM_WIN == (1 << PTR_W));

   logic [PTR_W-1:0] cwp_q, cwp_d, cwp_inc, cwp_dec;
   logic [CNT_W-1:0] res_q, res_d;
   logic             ovf_q, ovf_d, unf_q, unf_d;
   win_op_e          op;

   generate
      if (PTR_POW2) begin : g_ptr_pow2
         assign cwp_inc = cwp_q + 1'b1;
         assign cwp_dec = cwp_q - 1'b1;
      end else begin : g_ptr_mod
         assign cwp_inc = (cwp_q == PTR_W'(NUM_WIN - 1)) ? '0 : cwp_q + 1'b1;
         assign cwp_dec = (cwp_q == '0) ? PTR_W'(NUM_WIN - 1) : cwp_q - 1'b1;
      end
   endgenerate

   always_comb begin
      op    = decode_op(call_i, ret_i);
      cwp_d = cwp_q;
      res_d = res_q;
      ovf_d = ovf_q;
      unf_d = unf_q;
      if (ovf_q) begin
         if (spill_ack_i) begin
            ovf_d = 1'b0;
            res_d = res_q - 1'b1;
         end
      end else if (unf_q) begin
         if (fill_ack_i) begin
            unf_d = 1'b0;
            res_d = res_q + 1'b1;
         end
      end else begin
         case (op)
            WOP_CALL: begin
               if (res_q == CNT_W'(MAX_RESIDENT)) begin
                  ovf_d = 1'b1;
               end else begin
                  cwp_d = cwp_inc;
                  res_d = res_q + 1'b1;
               end
            end
            WOP_RET: begin
               if (res_q == CNT_W'(1)) begin
                  unf_d = 1'b1;
               end else begin
                  cwp_d = cwp_dec;
                  res_d = res_q - 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cwp_q <= '0;
         res_q <= CNT_W'(1);
         ovf_q <= 1'b0;
         unf_q <= 1'b0;
      end else begin
         cwp_q <= cwp_d;
         res_q <= res_d;
         ovf_q <= ovf_d;
         unf_q <= unf_d;
      end
   end

   assign cwp_o      = cwp_q;
   assign resident_o = res_q;
   assign ovf_o      = ovf_q;
   assign unf_o      = unf_q;

endmodule

// File: rtl/regwin_store.sv
module regwin_store #(
   parameter int NUM_PHYS = 64,
   parameter int DATA_W   = 32,
   parameter int PREG_W   = 6
) (
   input  logic              clk,
   input  logic              wr_en_i,
   input  logic [PREG_W-1:0] wr_idx_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [PREG_W-1:0] rd_a_idx_i,
   output logic [DATA_W-1:0] rd_a_data_o,
   input  logic [PREG_W-1:0] rd_b_idx_i,
   output logic [DATA_W-1:0] rd_b_data_o
);
   logic [DATA_W-1:0] rows [NUM_PHYS];

   generate
      for (genvar g = 0; g < NUM_PHYS; g++) begin : g_row
         always_ff @(posedge clk) begin
            if (wr_en_i && (wr_idx_i == PREG_W'(g))) rows[g] <= wr_data_i;
         end
      end
   endgenerate

   assign rd_a_data_o = rows[rd_a_idx_i];
   assign rd_b_data_o = rows[rd_b_idx_i];

endmodule

// File: rtl/regwin_file.sv
module regwin_file #(
   parameter int NUM_PHYS     = 64,
   parameter int WIN_SIZE     = 16,
   parameter int WIN_STEP     = 8,
   parameter int MAX_RESIDENT = 7,
   parameter int DATA_W       = 32,
   localparam int NUM_WIN     = NUM_PHYS / WIN_STEP,
   localparam int PTR_W       = $clog2(NUM_WIN),
   localparam int LREG_W      = $clog2(WIN_SIZE),
   localparam int CNT_W       = $clog2(NUM_WIN + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LREG_W-1:0] rd_a_idx_i,
   output logic [DATA_W-1:0] rd_a_data_o,
   input  logic [LREG_W-1:0] rd_b_idx_i,
   output logic [DATA_W-1:0] rd_b_data_o,
   input  logic              wr_en_i,
   input  logic [LREG_W-1:0] wr_idx_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              call_i,
   input  logic              ret_i,
   input  logic              spill_ack_i,
   input  logic              fill_ack_i,
   output logic [PTR_W-1:0]  cwp_o,
   output logic [CNT_W-1:0]  resident_o,
   output logic              ovf_trap_o,
   output logic              unf_trap_o
);
   localparam int PREG_W  = $clog2(NUM_PHYS);
   localparam int N_PORTS = 3;

   generate
      if (NUM_PHYS % WIN_STEP != 0) begin : g_chk_step
         $error("NUM_PHYS must be a multiple of WIN_STEP");
      end
      if (WIN_SIZE != 2 * WIN_STEP) begin : g_chk_overlap
         $error("WIN_SIZE must be twice WIN_STEP for half-window overlap");
      end
      if (MAX_RESIDENT < 1 || MAX_RESIDENT >= NUM_WIN) begin : g_chk_res
         $error("MAX_RESIDENT must lie in 1 .. NUM_WIN-1");
      end
      if (WIN_SIZE != (1 << LREG_W)) begin : g_chk_win
         $error("WIN_SIZE must be a power of two");
      end
   endgenerate

   logic [PTR_W-1:0]  cwp;
   logic [LREG_W-1:0] lidx [N_PORTS];
   logic [PREG_W-1:0] pidx [N_PORTS];

   assign lidx[0] = rd_a_idx_i;
   assign lidx[1] = rd_b_idx_i;
   assign lidx[2] = wr_idx_i;

   generate
      for (genvar p = 0; p < N_PORTS; p++) begin : g_map
         regwin_map #(
            .NUM_PHYS (NUM_PHYS),
            .WIN_STEP (WIN_STEP),
            .PTR_W    (PTR_W),
            .LREG_W   (LREG_W),
            .PREG_W   (PREG_W)
         ) i_map (
            .ptr_i  (cwp),
            .lidx_i (lidx[p]),
            .pidx_o (pidx[p])
         );
      end
   endgenerate

   regwin_ctrl #(
      .NUM_WIN      (NUM_WIN),
      .MAX_RESIDENT (MAX_RESIDENT),
      .PTR_W        (PTR_W),
      .CNT_W        (CNT_W)
   ) i_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .call_i      (call_i),
      .ret_i       (ret_i),
      .spill_ack_i (spill_ack_i),
      .fill_ack_i  (fill_ack_i),
      .cwp_o       (cwp),
      .resident_o  (resident_o),
      .ovf_o       (ovf_trap_o),
      .unf_o       (unf_trap_o)
   );

   regwin_store #(
      .NUM_PHYS (NUM_PHYS),
      .DATA_W   (DATA_W),
      .PREG_W   (PREG_W)
   ) i_store (
      .clk         (clk),
      .wr_en_i     (wr_en_i),
      .wr_idx_i    (pidx[2]),
      .wr_data_i   (wr_data_i),
      .rd_a_idx_i  (pidx[0]),
      .rd_a_data_o (rd_a_data_o),
      .rd_b_idx_i  (pidx[1]),
      .rd_b_data_o (rd_b_data_o)
   );

   assign cwp_o = cwp;

endmodule

// File: rtl/regwin_chk.sv
module regwin_chk #(
   parameter int NUM_WIN      = 8,
   parameter int MAX_RESIDENT = 7,
   parameter int PTR_W        = 3,
   parameter int LREG_W       = 4,
   parameter int CNT_W        = 4,
   parameter int DATA_W       = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              call_i,
   input logic              ret_i,
   input logic              spill_ack_i,
   input logic              fill_ack_i,
   input logic              wr_en_i,
   input logic [LREG_W-1:0] wr_idx_i,
   input logic [DATA_W-1:0] wr_data_i,
   input logic [LREG_W-1:0] rd_a_idx_i,
   input logic [DATA_W-1:0] rd_a_data_o,
   input logic [PTR_W-1:0]  cwp_o,
   input logic [CNT_W-1:0]  resident_o,
   input logic              ovf_trap_o,
   input logic              unf_trap_o
);
   logic quiet;
   assign quiet = !ovf_trap_o && !unf_trap_o && !spill_ack_i && !fill_ack_i;

   AST_RES_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(resident_o) >= 1) && (int'(resident_o) <= MAX_RESIDENT)); // R6

   AST_ONE_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({ovf_trap_o, unf_trap_o}) <= 1); // R12

   AST_CALL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (call_i && !ret_i && quiet && int'(resident_o) < MAX_RESIDENT) |=>
      (int'(cwp_o) == (int'($past(cwp_o)) + 1) % NUM_WIN)); // R5

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (call_i && !ret_i && quiet && int'(resident_o) == MAX_RESIDENT) |=>
      (ovf_trap_o && $stable(cwp_o) && $stable(resident_o))); // R6

   AST_RET_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_i && !call_i && quiet && int'(resident_o) > 1) |=>
      (int'(cwp_o) == (int'($past(cwp_o)) + NUM_WIN - 1) % NUM_WIN)); // R7

   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_i && !call_i && quiet && int'(resident_o) == 1) |=>
      (unf_trap_o && $stable(cwp_o) && $stable(resident_o))); // R8

   AST_BOTH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (call_i && ret_i && !spill_ack_i && !fill_ack_i) |=>
      ($stable(cwp_o) && $stable(resident_o) && $stable(ovf_trap_o))); // R9

   AST_SPILL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_trap_o && spill_ack_i) |=>
      (!ovf_trap_o && resident_o == $past(resident_o) - 1'b1)); // R10

   AST_FILL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (unf_trap_o && fill_ack_i) |=>
      (!unf_trap_o && resident_o == $past(resident_o) + 1'b1)); // R11

   AST_TRAP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      ((ovf_trap_o || unf_trap_o) && !spill_ack_i && !fill_ack_i) |=>
      ($stable(cwp_o) && $stable(resident_o))); // R12

   AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && !call_i && !ret_i) |=>
      ((rd_a_idx_i != $past(wr_idx_i)) || (rd_a_data_o == $past(wr_data_i)))); // R4

endmodule

bind regwin_file regwin_chk #(
   .NUM_WIN      (NUM_WIN),
   .MAX_RESIDENT (MAX_RESIDENT),
   .PTR_W        (PTR_W),
   .LREG_W       (LREG_W),
   .CNT_W        (CNT_W),
   .DATA_W       (DATA_W)
) i_regwin_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .call_i      (call_i),
   .ret_i       (ret_i),
   .spill_ack_i (spill_ack_i),
   .fill_ack_i  (fill_ack_i),
   .wr_en_i     (wr_en_i),
   .wr_idx_i    (wr_idx_i),
   .wr_data_i   (wr_data_i),
   .rd_a_idx_i  (rd_a_idx_i),
   .rd_a_data_o (rd_a_data_o),
   .cwp_o       (cwp_o),
   .resident_o  (resident_o),
   .ovf_trap_o  (ovf_trap_o),
   .unf_trap_o  (unf_trap_o)
);

// File: tb/test_regwin_file.sv
module test_regwin_file;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
   logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
   logic        wr_en = 1'b0, call = 1'b0, ret = 1'b0, sack = 1'b0, fack = 1'b0;
   logic [2:0]  cwp;
   logic [3:0]  resident;
   logic        ovf, unf;

   always #5 clk = ~clk;

   regwin_file i_regwin_file (
      .clk         (clk),
      .rst_n       (rst_n),
      .rd_a_idx_i  (rd_a_idx),
      .rd_a_data_o (rd_a_data),
      .rd_b_idx_i  (rd_b_idx),
      .rd_b_data_o (rd_b_data),
      .wr_en_i     (wr_en),
      .wr_idx_i    (wr_idx),
      .wr_data_i   (wr_data),
      .call_i      (call),
      .ret_i       (ret),
      .spill_ack_i (sack),
      .fill_ack_i  (fack),
      .cwp_o       (cwp),
      .resident_o  (resident),
      .ovf_trap_o  (ovf),
      .unf_trap_o  (unf)
   );

   typedef struct {
      int          cwp;
      int          res;
      bit          ovf;
      bit          unf;
      bit          a_chk;
      logic [31:0] a;
      bit          b_chk;
      logic [31:0] b;
      string       req;
   } item_t;

   item_t       sb [$];
   item_t       mon_it;
   int          total = 0;
   int          bad = 0;

   // Reference state built from the requirements
   logic [31:0] m_mem [64];
   bit          m_kn  [64];
   int          m_cwp = 0, m_res = 1;
   bit          m_ovf = 0, m_unf = 0;

   function automatic int phys(input int w, input int l);
      return (8 * w + l) % 64;
   endfunction

   task automatic step(input bit c, input bit r, input bit sa, input bit fa,
                       input bit we, input int wi, input logic [31:0] wd,
                       input int ra, input int rb, input string req);
      item_t it;
      int    wp;
      call = c; ret = r; sack = sa; fack = fa;
      wr_en = we; wr_idx = wi[3:0]; wr_data = wd;
      rd_a_idx = ra[3:0]; rd_b_idx = rb[3:0];
      wp = phys(m_cwp, wi);
      #1;
      if (we && ra == wi && m_kn[wp]) begin
         total++;
         if (rd_a_data !== m_mem[wp]) begin
            bad++;
            $display("FAIL R4 same-cycle read: actual=%h expected=%h", rd_a_data, m_mem[wp]);
         end
      end
      if (we) begin
         m_mem[wp] = wd;
         m_kn[wp]  = 1'b1;
      end
      if (m_ovf) begin
         if (sa) begin m_ovf = 0; m_res--; end
      end else if (m_unf) begin
         if (fa) begin m_unf = 0; m_res++; end
      end else if (c && !r) begin
         if (m_res == 7) m_ovf = 1;
         else begin m_cwp = (m_cwp + 1) % 8; m_res++; end
      end else if (r && !c) begin
         if (m_res == 1) m_unf = 1;
         else begin m_cwp = (m_cwp + 7) % 8; m_res--; end
      end
      it.cwp = m_cwp; it.res = m_res; it.ovf = m_ovf; it.unf = m_unf;
      it.a_chk = m_kn[phys(m_cwp, ra)]; it.a = m_mem[phys(m_cwp, ra)];
      it.b_chk = m_kn[phys(m_cwp, rb)]; it.b = m_mem[phys(m_cwp, rb)];
      it.req = req;
      sb.push_back(it);
      @(negedge clk);
   endtask

   task automatic idle(input int ra, input int rb, input string req);
      step(0, 0, 0, 0, 0, 0, '0, ra, rb, req);
   endtask

   // Monitor: pops one expectation per cycle, after the edge has settled
   always @(posedge clk) begin
      #2;
      if (sb.size() > 0) begin
         mon_it = sb.pop_front();
         total++;
         if (int'(cwp) != mon_it.cwp || int'(resident) != mon_it.res ||
             ovf !== mon_it.ovf || unf !== mon_it.unf) begin
            bad++;
            $display("FAIL %s state: actual cwp=%0d res=%0d ovf=%b unf=%b expected cwp=%0d res=%0d ovf=%b unf=%b",
                     mon_it.req, cwp, resident, ovf, unf,
                     mon_it.cwp, mon_it.res, mon_it.ovf, mon_it.unf);
         end else if (mon_it.a_chk && rd_a_data !== mon_it.a) begin
            bad++;
            $display("FAIL %s port A: actual=%h expected=%h", mon_it.req, rd_a_data, mon_it.a);
         end else if (mon_it.b_chk && rd_b_data !== mon_it.b) begin
            bad++;
            $display("FAIL %s port B: actual=%h expected=%h", mon_it.req, rd_b_data, mon_it.b);
         end
      end
   end

   initial begin
      #2_000_000;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 64; i++) begin m_mem[i] = '0; m_kn[i] = 0; end
      repeat (3) @(negedge clk);
      total++;
      if (cwp !== 3'd0 || resident !== 4'd1 || ovf !== 1'b0 || unf !== 1'b0) begin
         bad++;
         $display("FAIL R1 in reset: actual cwp=%0d res=%0d ovf=%b unf=%b expected 0 1 0 0",
                  cwp, resident, ovf, unf);
      end
      rst_n = 1'b1;
      idle(0, 0, "R1");

      // R2: fill window 0 through the logical numbering
      for (int l = 0; l < 16; l++) step(0, 0, 0, 0, 1, l, 32'h100 + l, l, 15 - l, "R2");

      step(1, 0, 0, 0, 0, 0, '0, 0, 0, "R5");                  // R5: window 0 -> 1
      for (int l = 0; l < 8; l++) idle(l, 7 - l, "R3");       // R3: shared half
      step(0, 0, 0, 0, 1, 3, 32'hABCD_0003, 3, 11, "R4");     // R4: read-during-write

      step(0, 1, 0, 0, 0, 0, '0, 11, 3, "R7");                 // R7: back to window 0
      idle(11, 12, "R7");

      step(0, 1, 0, 0, 0, 0, '0, 0, 0, "R8");                  // R8: no resident caller
      step(1, 0, 0, 0, 0, 0, '0, 0, 0, "R12");                 // R12: call while trapped
      step(0, 1, 0, 0, 0, 0, '0, 0, 0, "R12");                 // R12: return while trapped
      step(0, 0, 0, 1, 0, 0, '0, 0, 0, "R11");                 // R11: fill acknowledged
      step(0, 1, 0, 0, 0, 0, '0, 8, 9, "R13");                 // R13: retried return wraps 0 -> 7
      idle(8, 15, "R13");

      for (int k = 0; k < 6; k++) step(1, 0, 0, 0, 0, 0, '0, 0, 0, "R5");
      step(1, 0, 0, 0, 0, 0, '0, 0, 0, "R6");                  // R6: window limit reached
      step(0, 1, 0, 0, 0, 0, '0, 0, 0, "R12");
      step(0, 0, 1, 0, 0, 0, '0, 0, 0, "R10");                 // R10: spill acknowledged
      step(1, 0, 0, 0, 0, 0, '0, 0, 0, "R10");                 // R10: retried call
      step(1, 1, 0, 0, 0, 0, '0, 0, 0, "R9");                  // R9: both strobes
      step(1, 0, 0, 0, 0, 0, '0, 0, 0, "R6");
      idle(0, 0, "R6");
      @(negedge clk);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule